// File: doc/BRIEF.md
# SDRAM Self-Refresh Sequencer

This block lives inside an SDRAM controller and handles the handshake that puts the memory into its low-power self-refresh state and brings it back. A sleep request from the controller makes the block close every bank with a precharge to all banks. It waits out the row-precharge time and then lowers CKE in the same cycle as an AUTO REFRESH command. From that point the device refreshes itself. The block keeps CKE low for at least the minimum active time and drives command inhibit on the bus while CKE is low.

A wake request may arrive at any time after entry has started. The block remembers it. Once the minimum low time has passed and the clock-stable input is high, the block raises CKE. It then issues only NOP for the exit-recovery window and follows with a fresh AUTO REFRESH. In that same cycle it pulses a strobe so the controller restarts its periodic refresh timer.

Each timing limit is given in nanoseconds together with the clock period. The block turns each limit into a cycle count with the rule count = max(ceil(ns / period), 2). With the default parameters (20 ns clock, 20/44/75 ns) the counts are 2 cycles for precharge, 3 for minimum low time and 4 for exit recovery.

Top module: `sdram_srf_seq`

## Requirements
- R1: After reset the block drives CKE high and command inhibit (cs_n=1). busy, in-self-refresh and the restart strobe are all low.
- R2: A sleep request sampled while idle gives, in the next cycle, a PRECHARGE (cs_n=0, ras_n=0, cas_n=1, we_n=0) with a10 high and CKE high.
- R3: An AUTO REFRESH (cs_n=0, ras_n=0, cas_n=0, we_n=1) is issued with CKE low exactly the precharge count of cycles after the PRECHARGE. Only NOP (cs_n=0, ras_n=cas_n=we_n=1) is issued in the cycles between.
- R4: CKE stays low for at least the minimum-low count of cycles, counting the entry cycle. Every cycle with CKE low after the entry cycle carries command inhibit.
- R5: CKE rises only in the cycle after one in which clk_stable_i was high.
- R6: A wake request given before the minimum low time has passed is held. CKE then rises exactly the minimum-low count of cycles after the entry cycle, even though the request was a single-cycle pulse.
- R7: From the cycle CKE rises, NOP is issued for the exit-recovery count of cycles, which is never below 2. Then an AUTO REFRESH is issued with CKE high, and rt_restart_o is high for that one cycle only.
- R8: A sleep request while busy has no effect. The sequence keeps its timing, and after it completes the block stays idle.
- R9: A wake request while idle has no effect. busy stays low and CKE stays high.
- R10: busy_o is high from the PRECHARGE cycle through the closing AUTO REFRESH cycle. in_sr_o is high exactly while CKE is low.
- R11: With a wake request pending and clk_stable_i low, the block stays in self refresh for any length of time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_req_i | input | 1 | Request to enter self refresh, sampled while idle |
| wake_req_i | input | 1 | Request to leave self refresh, held until acted on |
| clk_stable_i | input | 1 | Clock is stable; CKE may be raised |
| cke_o | output | 1 | Clock enable to the memory |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| a10_o | output | 1 | Address bit 10; high selects all banks on precharge |
| ba_o | output | BA_W | Bank address, driven zero (unused by these commands) |
| busy_o | output | 1 | Sequence in progress |
| in_sr_o | output | 1 | Device held in self refresh (CKE low) |
| rt_restart_o | output | 1 | One-cycle strobe to restart the periodic refresh timer |

## Verification
All outputs are decoded from the registered state. A request sampled at one rising edge therefore shows up on the pins in the cycle right after that edge. The PRECHARGE follows a sleep request by one cycle. The entry AUTO REFRESH follows the PRECHARGE by the precharge count. CKE rises the minimum-low count after entry, or later if the clock is not yet stable. The closing AUTO REFRESH and the restart strobe follow the CKE rise by the exit-recovery count. The bench drives inputs and samples outputs on the falling edge, and it advances one clock per sample. Each scenario then checks its expected command, CKE level and status on the exact cycle given by these counts, which the bench computes from its own copy of the rounding rule.

// File: rtl/sdram_srf_pkg.sv
package sdram_srf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_RP,
    ST_ENTER,
    ST_SELF,
    ST_EXIT,
    ST_AREF
  } srf_st_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sd_cmd_t;

  localparam sd_cmd_t CMD_INH  = 4'b1111;
  localparam sd_cmd_t CMD_NOP  = 4'b0111;
  localparam sd_cmd_t CMD_PRE  = 4'b0010;
  localparam sd_cmd_t CMD_AREF = 4'b0001;

  // ceil(ns / period), never below two cycles
  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 2) ? 2 : c;
  endfunction

endpackage

// File: rtl/srf_timer.sv
module srf_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/srf_fsm.sv
module srf_fsm
  import sdram_srf_pkg::*;
#(
  parameter int CNT_W  = 3,
  parameter int RP_LD  = 0,
  parameter int RAS_LD = 1,
  parameter int XSR_LD = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_req_i,
  input  logic             wake_req_i,
  input  logic             clk_stable_i,
  input  logic             zero_i,
  output srf_st_e          st_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o
);

  srf_st_e st_q, st_d;
  logic    pend_q;
  logic    go_exit;

  // wake is latched from the start of entry until exit begins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                pend_q <= 1'b0;
    else if (st_q == ST_IDLE || st_q == ST_EXIT) pend_q <= 1'b0;
    else if (wake_req_i)                        pend_q <= 1'b1;
  end

  assign go_exit = zero_i && clk_stable_i && (pend_q || wake_req_i);

  always_comb begin
    st_d       = st_q;
    load_o     = 1'b0;
    load_val_o = '0;
    unique case (st_q)
      ST_IDLE:  if (sleep_req_i) st_d = ST_PRE;
      ST_PRE: begin
        st_d       = ST_RP;
        load_o     = 1'b1;
        load_val_o = CNT_W'(RP_LD);
      end
      ST_RP:    if (zero_i) st_d = ST_ENTER;
      ST_ENTER: begin
        st_d       = ST_SELF;
        load_o     = 1'b1;
        load_val_o = CNT_W'(RAS_LD);
      end
      ST_SELF: if (go_exit) begin
        st_d       = ST_EXIT;
        load_o     = 1'b1;
        load_val_o = CNT_W'(XSR_LD);
      end
      ST_EXIT:  if (zero_i) st_d = ST_AREF;
      ST_AREF:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign st_o = st_q;

endmodule

// File: rtl/srf_cmd_enc.sv
module srf_cmd_enc
  import sdram_srf_pkg::*;
(
  input  srf_st_e st_i,
  output logic    cke_o,
  output sd_cmd_t cmd_o,
  output logic    a10_o,
  output logic    busy_o,
  output logic    in_sr_o,
  output logic    restart_o
);

  always_comb begin
    cke_o     = 1'b1;
    cmd_o     = CMD_INH;
    a10_o     = 1'b0;
    restart_o = 1'b0;
    unique case (st_i)
      ST_PRE: begin
        cmd_o = CMD_PRE;
        a10_o = 1'b1;
      end
      ST_RP:    cmd_o = CMD_NOP;
      ST_ENTER: begin
        cmd_o = CMD_AREF;
        cke_o = 1'b0;
      end
      ST_SELF:  cke_o = 1'b0;
      ST_EXIT:  cmd_o = CMD_NOP;
      ST_AREF: begin
        cmd_o     = CMD_AREF;
        restart_o = 1'b1;
      end
      default:  cmd_o = CMD_INH;
    endcase
  end

  assign busy_o  = (st_i != ST_IDLE);
  assign in_sr_o = (st_i == ST_ENTER) || (st_i == ST_SELF);

endmodule

// File: rtl/sdram_srf_seq.sv
module sdram_srf_seq
  import sdram_srf_pkg::*;
#(
  parameter int CLK_NS  = 20,
  parameter int TRP_NS  = 20,
  parameter int TRAS_NS = 44,
  parameter int TXSR_NS = 75,
  parameter int BA_W    = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sleep_req_i,
  input  logic            wake_req_i,
  input  logic            clk_stable_i,
  output logic            cke_o,
  output logic            cs_n_o,
  output logic            ras_n_o,
  output logic            cas_n_o,
  output logic            we_n_o,
  output logic            a10_o,
  output logic [BA_W-1:0] ba_o,
  output logic            busy_o,
  output logic            in_sr_o,
  output logic            rt_restart_o
);

  localparam int TRP_CYC  = ns2cyc(TRP_NS, CLK_NS);
  localparam int TRAS_CYC = ns2cyc(TRAS_NS, CLK_NS);
  localparam int TXSR_CYC = ns2cyc(TXSR_NS, CLK_NS);
  // timed states last load+1 cycles; PRE and ENTER supply one more each
  localparam int RP_LD    = TRP_CYC - 2;
  localparam int RAS_LD   = TRAS_CYC - 2;
  localparam int XSR_LD   = TXSR_CYC - 1;
  localparam int MAX_LD   = (XSR_LD > RAS_LD) ? ((XSR_LD > RP_LD) ? XSR_LD : RP_LD)
                                              : ((RAS_LD > RP_LD) ? RAS_LD : RP_LD);
  localparam int CNT_W    = $clog2(MAX_LD + 2);

  srf_st_e          st;
  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  sd_cmd_t          cmd;

  srf_fsm #(
    .CNT_W (CNT_W),
    .RP_LD (RP_LD),
    .RAS_LD(RAS_LD),
    .XSR_LD(XSR_LD)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sleep_req_i (sleep_req_i),
    .wake_req_i  (wake_req_i),
    .clk_stable_i(clk_stable_i),
    .zero_i      (tmr_zero),
    .st_o        (st),
    .load_o      (tmr_load),
    .load_val_o  (tmr_val)
  );

  srf_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .zero_o    (tmr_zero)
  );

  srf_cmd_enc u_enc (
    .st_i     (st),
    .cke_o    (cke_o),
    .cmd_o    (cmd),
    .a10_o    (a10_o),
    .busy_o   (busy_o),
    .in_sr_o  (in_sr_o),
    .restart_o(rt_restart_o)
  );

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd;
  assign ba_o = '0;

endmodule

// File: rtl/srf_seq_chk.sv
module srf_seq_chk
  import sdram_srf_pkg::*;
#(
  parameter int CLK_NS  = 20,
  parameter int TRP_NS  = 20,
  parameter int TRAS_NS = 44,
  parameter int TXSR_NS = 75
) (
  input logic clk_i,
  input logic rst_ni,
  input logic sleep_req_i,
  input logic clk_stable_i,
  input logic cke_o,
  input logic cs_n_o,
  input logic ras_n_o,
  input logic cas_n_o,
  input logic we_n_o,
  input logic a10_o,
  input logic busy_o,
  input logic in_sr_o,
  input logic rt_restart_o
);

  localparam int TRP_CYC  = ns2cyc(TRP_NS, CLK_NS);
  localparam int TRAS_CYC = ns2cyc(TRAS_NS, CLK_NS);
  localparam int TXSR_CYC = ns2cyc(TXSR_NS, CLK_NS);
  localparam int CW       = $clog2(TRP_CYC + TRAS_CYC + TXSR_CYC + 1) + 1;

  logic          is_pre, is_aref, is_nop;
  logic [CW-1:0] rp_cnt, lo_cnt, xs_cnt;

  assign is_pre  = !cs_n_o && {ras_n_o, cas_n_o, we_n_o} == 3'b010;
  assign is_aref = !cs_n_o && {ras_n_o, cas_n_o, we_n_o} == 3'b001;
  assign is_nop  = !cs_n_o && {ras_n_o, cas_n_o, we_n_o} == 3'b111;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rp_cnt <= '0;
      lo_cnt <= '0;
      xs_cnt <= '1;
    end else begin
      if (is_pre) rp_cnt <= CW'(1);
      else if (rp_cnt != '0 && rp_cnt != '1) rp_cnt <= rp_cnt + 1'b1;
      if (cke_o) lo_cnt <= '0;
      else if (lo_cnt != '1) lo_cnt <= lo_cnt + 1'b1;
      if (!cke_o) xs_cnt <= '0;
      else if (xs_cnt != '1) xs_cnt <= xs_cnt + 1'b1;
    end
  end

  p_sleep_pre_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && sleep_req_i) |=> is_pre);
  p_pre_a10_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_pre |-> (a10_o && cke_o));
  p_entry_cmd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_o) |-> is_aref);
  p_rp_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_aref && !cke_o) |-> (rp_cnt >= CW'(TRP_CYC)));
  p_sr_inhibit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_o && !$fell(cke_o)) |-> cs_n_o);
  p_min_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> (lo_cnt >= CW'(TRAS_CYC)));
  p_stable_exit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> $past(clk_stable_i));
  p_xsr_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_o && xs_cnt < CW'(TXSR_CYC)) |-> (cs_n_o || is_nop));
  p_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rt_restart_o |-> (is_aref && cke_o));
  p_in_sr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_sr_o != cke_o);

endmodule

bind sdram_srf_seq srf_seq_chk #(
  .CLK_NS (CLK_NS),
  .TRP_NS (TRP_NS),
  .TRAS_NS(TRAS_NS),
  .TXSR_NS(TXSR_NS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sleep_req_i (sleep_req_i),
  .clk_stable_i(clk_stable_i),
  .cke_o       (cke_o),
  .cs_n_o      (cs_n_o),
  .ras_n_o     (ras_n_o),
  .cas_n_o     (cas_n_o),
  .we_n_o      (we_n_o),
  .a10_o       (a10_o),
  .busy_o      (busy_o),
  .in_sr_o     (in_sr_o),
  .rt_restart_o(rt_restart_o)
);

// File: tb/sdram_srf_seq_bench.sv
module sdram_srf_seq_bench;

  localparam int CLK_NS  = 20;
  localparam int TRP_NS  = 20;
  localparam int TRAS_NS = 44;
  localparam int TXSR_NS = 75;
  localparam int BA_W    = 2;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    if (c < 2) c = 2;
    return c;
  endfunction

  localparam int N_RP  = cyc(TRP_NS);
  localparam int N_RAS = cyc(TRAS_NS);
  localparam int N_XSR = cyc(TXSR_NS);

  // command codes used by the bench
  localparam int C_INH = 0, C_NOP = 1, C_PRE = 2, C_AREF = 3, C_BAD = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sleep_req_i = 1'b0, wake_req_i = 1'b0, clk_stable_i = 1'b0;
  logic cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, a10_o;
  logic [BA_W-1:0] ba_o;
  logic busy_o, in_sr_o, rt_restart_o;

  int  vec = 0, miss = 0;
  bit  done = 1'b0;

  always #10 clk_i = ~clk_i;

  sdram_srf_seq #(
    .CLK_NS(CLK_NS), .TRP_NS(TRP_NS), .TRAS_NS(TRAS_NS), .TXSR_NS(TXSR_NS), .BA_W(BA_W)
  ) u_sdram_srf_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .sleep_req_i(sleep_req_i), .wake_req_i(wake_req_i),
    .clk_stable_i(clk_stable_i), .cke_o(cke_o), .cs_n_o(cs_n_o), .ras_n_o(ras_n_o),
    .cas_n_o(cas_n_o), .we_n_o(we_n_o), .a10_o(a10_o), .ba_o(ba_o), .busy_o(busy_o),
    .in_sr_o(in_sr_o), .rt_restart_o(rt_restart_o)
  );

  function automatic int cmd_now();
    if (cs_n_o) return C_INH;
    case ({ras_n_o, cas_n_o, we_n_o})
      3'b111:  return C_NOP;
      3'b010:  return C_PRE;
      3'b001:  return C_AREF;
      default: return C_BAD;
    endcase
  endfunction

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    vec++;
    if (act != exp) begin
      miss++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    chk("R1 cke", int'(cke_o), 1);
    chk("R1 cmd", cmd_now(), C_INH);
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 in_sr", int'(in_sr_o), 0);
    chk("R1 restart", int'(rt_restart_o), 0);
  endtask

  task automatic t_idle_wake();
    wake_req_i = 1'b1;
    tick();
    wake_req_i = 1'b0;
    chk("R9 busy", int'(busy_o), 0);
    chk("R9 cke", int'(cke_o), 1);
    tick();
    chk("R9 cmd", cmd_now(), C_INH);
  endtask

  // ends at the negedge of the entry cycle
  task automatic enter_sr();
    sleep_req_i = 1'b1;
    tick();
    sleep_req_i = 1'b0;
    chk("R2 cmd", cmd_now(), C_PRE);
    chk("R2 a10", int'(a10_o), 1);
    chk("R2 cke", int'(cke_o), 1);
    chk("R10 busy", int'(busy_o), 1);
    for (int k = 1; k < N_RP; k++) begin
      tick();
      chk("R3 rp nop", cmd_now(), C_NOP);
    end
    tick();
    chk("R3 entry cmd", cmd_now(), C_AREF);
    chk("R3 entry cke", int'(cke_o), 0);
    chk("R10 in_sr", int'(in_sr_o), 1);
  endtask

  // called one cycle before CKE is due to rise
  task automatic leave_sr(input bit poke);
    tick();
    chk("R5 cke rise", int'(cke_o), 1);
    chk("R7 first nop", cmd_now(), C_NOP);
    chk("R10 in_sr off", int'(in_sr_o), 0);
    if (poke) sleep_req_i = 1'b1;
    for (int k = 1; k < N_XSR; k++) begin
      tick();
      chk("R7 xsr nop", cmd_now(), C_NOP);
      chk("R7 no restart", int'(rt_restart_o), 0);
    end
    tick();
    chk("R7 exit aref", cmd_now(), C_AREF);
    chk("R7 exit cke", int'(cke_o), 1);
    chk("R7 restart", int'(rt_restart_o), 1);
    sleep_req_i = 1'b0;
    tick();
    chk("R10 idle busy", int'(busy_o), 0);
    chk("R7 restart off", int'(rt_restart_o), 0);
    tick();
    chk("R8 stays idle", int'(busy_o), 0);
    chk("R8 idle cmd", cmd_now(), C_INH);
  endtask

  task automatic t_early_wake();
    enter_sr();
    wake_req_i   = 1'b1;
    clk_stable_i = 1'b1;
    tick();
    wake_req_i = 1'b0;
    chk("R6 held low", int'(cke_o), 0);
    chk("R4 inhibit", cmd_now(), C_INH);
    for (int k = 2; k < N_RAS; k++) begin
      tick();
      chk("R4 min low", int'(cke_o), 0);
      chk("R4 inhibit", cmd_now(), C_INH);
    end
    leave_sr(1'b0);
  endtask

  task automatic t_stall_busy_sleep();
    enter_sr();
    clk_stable_i = 1'b0;
    wake_req_i   = 1'b1;
    tick();
    wake_req_i  = 1'b0;
    sleep_req_i = 1'b1;
    for (int k = 1; k <= 24; k++) begin
      tick();
      if (k == 2) sleep_req_i = 1'b0;
      chk("R11 cke low", int'(cke_o), 0);
      chk("R5 no exit", int'(in_sr_o), 1);
      chk("R8 inhibit", cmd_now(), C_INH);
    end
    clk_stable_i = 1'b1;
    leave_sr(1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_idle_wake();
    t_early_wake();
    t_stall_busy_sleep();
    t_early_wake();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      miss++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
      $finish;
    end
  end

endmodule